// File: doc/BRIEF.md
# UART Interrupt Mask and Status Bank

This block holds the interrupt registers of a serial port. Software never writes the mask directly. It writes ones into a set-only address to unmask sources and ones into a clear-only address to mask them again. Both of those addresses read back as zero. The current mask is read from its own read-only address. Per-cycle event pulses from the receiver and the FIFOs are latched into a sticky status register, but only for sources whose mask bit is already set. Software clears status bits by writing ones to the status address. The single interrupt line is high while any status bit is set.

A separate raw-condition view gives the current FIFO levels whatever the mask holds. This lets a driver poll the FIFOs without taking interrupts. The bus is a simple single-port interface. A write takes effect on the clock edge at which `bus_wr` is high. Read data is combinational from `bus_addr`.

The bank has no state machine. It has one register per source bit for the mask and one for the status.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Reset, asserted low and asynchronous, clears every mask bit and every status bit, and drives `irq` low.
- R2: A write to byte address 0x08 sets each mask bit whose write-data bit is 1. Write-data bits that are 0 leave their mask bits unchanged. The mask reads back at address 0x10 from the cycle after the write.
- R3: A write to address 0x0C clears each mask bit whose write-data bit is 1. Zero bits have no effect.
- R4: Reads of 0x08 and 0x0C return zero. Writes to 0x10 (mask) and 0x2C (raw view) change nothing.
- R5: An event pulse on source bit i sets status bit i at the next clock edge only if mask bit i is 1 at that edge. A masked pulse is lost and is not captured later. Source bit positions are: 0 RX trigger, 1 RX empty, 2 RX full, 3 TX empty, 4 TX full, 5 overrun, 6 framing, 7 parity, 8 RX timeout, and 9–12 spare.
- R6: A write to address 0x14 clears each status bit whose write-data bit is 1. Zero bits have no effect. The status register reads back at 0x14.
- R7: If an unmasked event and a clear of the same status bit occur in the same cycle, the bit stays set.
- R8: `irq` is high exactly while at least one status bit is set. It rises only in the cycle after an unmasked event.
- R9: Address 0x2C reads the current levels in the same cycle, whatever the mask holds: RX trigger in bit 0, RX empty in bit 1, TX empty in bit 3, TX full in bit 4, and zero in all other bits. The levels never change the status register.
- R10: Write-data bits 13 and above are ignored. Read-data bits 13 and above are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| evt_pulse | input | 13 | One-cycle event pulses, one per source |
| rx_trig_lvl | input | 1 | RX FIFO at or above its trigger level |
| rx_empty_lvl | input | 1 | RX FIFO empty |
| tx_empty_lvl | input | 1 | TX FIFO empty |
| tx_full_lvl | input | 1 | TX FIFO full |
| irq | output | 1 | Interrupt request |

## Verification
Each set or clear pattern mixes ones and zeros. This shows that a one acts and a zero is neutral. A write of all zeros shows that no write-through path exists. Event pulses go both to bits that were just masked and to bits left unmasked. This separates capture gated by the mask from capture of every event. An event and a clear of the same bit in one cycle decides which of the two wins. The raw view is read with levels that disagree with the mask and with the status. This shows that it bypasses both and leaves the status untouched.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int SRC_N = 13;

    // register byte addresses
    localparam int OFF_SET  = 'h08;
    localparam int OFF_CLR  = 'h0C;
    localparam int OFF_MASK = 'h10;
    localparam int OFF_STAT = 'h14;
    localparam int OFF_RAW  = 'h2C;

    // source bit positions shared by every register
    localparam int B_RXTRIG = 0;
    localparam int B_RXEMPT = 1;
    localparam int B_RXFULL = 2;
    localparam int B_TXEMPT = 3;
    localparam int B_TXFULL = 4;
    localparam int B_OVR    = 5;
    localparam int B_FRM    = 6;
    localparam int B_PAR    = 7;
    localparam int B_TOUT   = 8;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_SET,
        REG_CLR,
        REG_MASK,
        REG_STAT,
        REG_RAW
    } reg_sel_e;
endpackage

// File: rtl/uart_irq_decode.sv
module uart_irq_decode
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    always_comb begin
        unique case (addr)
            ADDR_W'(OFF_SET):  sel = REG_SET;
            ADDR_W'(OFF_CLR):  sel = REG_CLR;
            ADDR_W'(OFF_MASK): sel = REG_MASK;
            ADDR_W'(OFF_STAT): sel = REG_STAT;
            ADDR_W'(OFF_RAW):  sel = REG_RAW;
            default:           sel = REG_NONE;
        endcase
    end
endmodule

// File: rtl/uart_irq_mask.sv
module uart_irq_mask #(
    parameter int SRC_N = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] set_bits,
    input  logic [SRC_N-1:0] clr_bits,
    output logic [SRC_N-1:0] mask_q
);
    logic [SRC_N-1:0] mask_d;

    // clear wins over set when both name one bit
    always_comb mask_d = (mask_q | set_bits) & ~clr_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status #(
    parameter int SRC_N = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] evt,
    input  logic [SRC_N-1:0] mask,
    input  logic [SRC_N-1:0] clr_bits,
    output logic [SRC_N-1:0] stat_q
);
    for (genvar i = 0; i < SRC_N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                stat_q[i] <= 1'b0;
            else if (evt[i] && mask[i]) stat_q[i] <= 1'b1;
            else if (clr_bits[i])       stat_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_irq_rdmux.sv
module uart_irq_rdmux
    import uart_irq_pkg::*;
#(
    parameter int SRC_N  = 13,
    parameter int DATA_W = 32
) (
    input  reg_sel_e          sel,
    input  logic [SRC_N-1:0]  mask,
    input  logic [SRC_N-1:0]  stat,
    input  logic [SRC_N-1:0]  raw,
    output logic [DATA_W-1:0] rdata
);
    logic [SRC_N-1:0] pick;

    always_comb begin
        unique case (sel)
            REG_MASK: pick = mask;
            REG_STAT: pick = stat;
            REG_RAW:  pick = raw;
            default:  pick = '0;
        endcase
        rdata = DATA_W'(pick);
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int SRC_W  = SRC_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [SRC_W-1:0]  evt_pulse,
    input  logic              rx_trig_lvl,
    input  logic              rx_empty_lvl,
    input  logic              tx_empty_lvl,
    input  logic              tx_full_lvl,
    output logic              irq
);
    reg_sel_e         sel;
    logic [SRC_W-1:0] wbits;
    logic [SRC_W-1:0] set_bits;
    logic [SRC_W-1:0] clr_bits;
    logic [SRC_W-1:0] sclr_bits;
    logic [SRC_W-1:0] mask_q;
    logic [SRC_W-1:0] stat_q;
    logic [SRC_W-1:0] raw;
    logic             unused_wdata_hi;

    assign wbits           = bus_wdata[SRC_W-1:0];
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:SRC_W];

    uart_irq_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr (bus_addr),
        .sel  (sel)
    );

    always_comb begin
        set_bits  = (bus_wr && sel == REG_SET)  ? wbits : '0;
        clr_bits  = (bus_wr && sel == REG_CLR)  ? wbits : '0;
        sclr_bits = (bus_wr && sel == REG_STAT) ? wbits : '0;
    end

    always_comb begin
        raw           = '0;
        raw[B_RXTRIG] = rx_trig_lvl;
        raw[B_RXEMPT] = rx_empty_lvl;
        raw[B_TXEMPT] = tx_empty_lvl;
        raw[B_TXFULL] = tx_full_lvl;
    end

    uart_irq_mask #(.SRC_N(SRC_W)) mask_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (set_bits),
        .clr_bits (clr_bits),
        .mask_q   (mask_q)
    );

    uart_irq_status #(.SRC_N(SRC_W)) stat_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_pulse),
        .mask     (mask_q),
        .clr_bits (sclr_bits),
        .stat_q   (stat_q)
    );

    uart_irq_rdmux #(.SRC_N(SRC_W), .DATA_W(DATA_W)) rd_i (
        .sel   (sel),
        .mask  (mask_q),
        .stat  (stat_q),
        .raw   (raw),
        .rdata (bus_rdata)
    );

    assign irq = |stat_q;
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int SRC_W  = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [SRC_W-1:0]  evt_pulse,
    input logic              rx_empty_lvl,
    input logic              irq,
    input logic [SRC_W-1:0]  mask_q,
    input logic [SRC_W-1:0]  stat_q
);
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R2: bits written to the set address are present next cycle
    a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(bus_wr && bus_addr == ADDR_W'(OFF_SET))) |->
        ((mask_q & $past(bus_wdata[SRC_W-1:0])) == $past(bus_wdata[SRC_W-1:0])));

    // R3: bits written to the clear address are gone next cycle
    a_r3_clr_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(bus_wr && bus_addr == ADDR_W'(OFF_CLR))) |->
        ((mask_q & $past(bus_wdata[SRC_W-1:0])) == '0));

    // R4: the set and clear addresses read as zero
    a_r4_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFF_SET) || bus_addr == ADDR_W'(OFF_CLR)) |-> (bus_rdata == '0));

    // R5: a newly set status bit had its mask bit set
    a_r5_only_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((stat_q & ~$past(stat_q) & ~$past(mask_q)) == '0));

    // R7: an unmasked event always lands, even against a clear
    a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((stat_q & $past(evt_pulse & mask_q)) == $past(evt_pulse & mask_q)));

    // R8: interrupt rises only after an unmasked event
    a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(irq)) |-> ($past(evt_pulse & mask_q) != '0));

    // R9: raw view shows the RX empty level
    a_r9_raw_level: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFF_RAW)) |-> (bus_rdata[B_RXEMPT] == rx_empty_lvl));

    // R10: upper read bits are zero
    a_r10_rd_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[DATA_W-1:SRC_W] == '0));
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SRC_W  (SRC_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .evt_pulse    (evt_pulse),
    .rx_empty_lvl (rx_empty_lvl),
    .irq          (irq),
    .mask_q       (mask_q),
    .stat_q       (stat_q)
);

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [12:0] evt_pulse = 13'h0;
    logic        rx_trig_lvl = 1'b0;
    logic        rx_empty_lvl = 1'b0;
    logic        tx_empty_lvl = 1'b0;
    logic        tx_full_lvl = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    uart_irq_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .evt_pulse    (evt_pulse),
        .rx_trig_lvl  (rx_trig_lvl),
        .rx_empty_lvl (rx_empty_lvl),
        .tx_empty_lvl (tx_empty_lvl),
        .tx_full_lvl  (tx_full_lvl),
        .irq          (irq)
    );

    // {wr, addr, wdata, evt, read addr, expected read, expected irq}
    localparam logic [56:0] VEC [14] = '{
        {1'b1, 8'h08, 13'h0129, 13'h0000, 8'h10, 13'h0129, 1'b0},
        {1'b1, 8'h08, 13'h0000, 13'h0000, 8'h10, 13'h0129, 1'b0},
        {1'b1, 8'h0C, 13'h0021, 13'h0000, 8'h10, 13'h0108, 1'b0},
        {1'b1, 8'h0C, 13'h0000, 13'h0000, 8'h10, 13'h0108, 1'b0},
        {1'b0, 8'h08, 13'h0000, 13'h0021, 8'h14, 13'h0000, 1'b0},
        {1'b0, 8'h08, 13'h0000, 13'h0108, 8'h14, 13'h0108, 1'b1},
        {1'b1, 8'h14, 13'h0008, 13'h0000, 8'h14, 13'h0100, 1'b1},
        {1'b1, 8'h14, 13'h0100, 13'h0100, 8'h14, 13'h0100, 1'b1},
        {1'b1, 8'h14, 13'h0100, 13'h0000, 8'h14, 13'h0000, 1'b0},
        {1'b0, 8'h00, 13'h0000, 13'h0000, 8'h08, 13'h0000, 1'b0},
        {1'b0, 8'h00, 13'h0000, 13'h0000, 8'h0C, 13'h0000, 1'b0},
        {1'b1, 8'h10, 13'h1FFF, 13'h0000, 8'h10, 13'h0108, 1'b0},
        {1'b1, 8'h14, 13'h0000, 13'h0008, 8'h14, 13'h0008, 1'b1},
        {1'b1, 8'h08, 13'h1E00, 13'h0000, 8'h10, 13'h1F08, 1'b1}
    };
    localparam string VTAG [14] = '{
        "R2 set", "R2 zero neutral", "R3 clear", "R3 zero neutral",
        "R5 masked dropped", "R5 unmasked latched", "R6 w1c partial",
        "R7 event beats clear", "R8 irq drops", "R4 set reads zero",
        "R4 clear reads zero", "R4 mask write ignored", "R5 tx empty",
        "R2 spare bits"
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic bus_cycle(input logic wr, input logic [7:0] a, input logic [31:0] d,
                             input logic [12:0] e, input logic [7:0] ra);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; evt_pulse = e;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 32'h0; evt_pulse = 13'h0; bus_addr = ra;
        #2;
    endtask

    task automatic read_at(input logic [7:0] ra);
        @(negedge clk);
        bus_addr = ra;
        #2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        // R1: reset state
        read_at(8'h10); check("R1 mask", bus_rdata, 32'h0);
        read_at(8'h14); check("R1 status", bus_rdata, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < 14; i++) begin
            bus_cycle(VEC[i][56], VEC[i][55:48], {19'h0, VEC[i][47:35]},
                      VEC[i][34:22], VEC[i][21:14]);
            check(VTAG[i], bus_rdata, {19'h0, VEC[i][13:1]});
            check({VTAG[i], " irq"}, {31'h0, irq}, {31'h0, VEC[i][0]});
        end

        // R10: upper write-data bits ignored
        bus_cycle(1'b1, 8'h08, 32'hFFFF_E000, 13'h0, 8'h10);
        check("R10 upper wdata", bus_rdata, 32'h0000_1F08);

        // R9: raw levels regardless of mask, no effect on status
        rx_trig_lvl = 1'b1; rx_empty_lvl = 1'b1; tx_empty_lvl = 1'b0; tx_full_lvl = 1'b1;
        read_at(8'h2C); check("R9 raw A", bus_rdata, 32'h13);
        rx_trig_lvl = 1'b0; rx_empty_lvl = 1'b0; tx_empty_lvl = 1'b1; tx_full_lvl = 1'b0;
        read_at(8'h2C); check("R9 raw B", bus_rdata, 32'h08);
        read_at(8'h14); check("R9 status untouched", bus_rdata, 32'h08);

        // R8: irq clears with the last status bit
        bus_cycle(1'b1, 8'h14, 32'h0000_1FFF, 13'h0, 8'h14);
        check("R8 all cleared", bus_rdata, 32'h0);
        check("R8 irq low", {31'h0, irq}, 32'h0);

        // R1: reset in mid-run
        bus_cycle(1'b0, 8'h00, 32'h0, 13'h0008, 8'h14);
        check("R1 pre-reset status", bus_rdata, 32'h08);
        @(negedge clk); rst_n = 1'b0;
        #2;
        check("R1 irq in reset", {31'h0, irq}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        read_at(8'h10); check("R1 mask after reset", bus_rdata, 32'h0);
        read_at(8'h14); check("R1 status after reset", bus_rdata, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule